// File: doc/BRIEF.md
# PHY Management Master with Address Scan

This block is a clause-22 management master for Ethernet PHYs. From a handful of control inputs it builds serial management frames on a derived clock (MDC) and a data line modelled as three signals: `mdo`, `mdo_en` and `mdi`. It can issue a single register read, whose 16-bit result lands in a read-data register, or a single register write that shifts out a control word.

MDC comes from the system clock through a power-of-two divider chosen by a 3-bit setting. The 32-bit all-ones preamble can be suppressed for PHYs that accept short frames. A continuous scan mode polls one register over and over. It can also step the PHY address by one after every poll, so a host can sweep a range of PHYs.

Status comes back as a busy flag, a read-data-valid flag, the PHY address of the current scan cycle and a one-cycle done pulse at the end of every frame.

Top module: `phy_mgmt_ctrl`

## Requirements
- R1: After reset, `busy`, `mdc`, `mdo_en`, `rd_valid`, `done` and `scan_phy` are all zero.
- R2: While a frame runs, each MDC half period lasts 2^`div_sel` system clocks. MDC is held low while idle.
- R3: A frame is sent MSB first in this order: 32 ones (unless suppressed), start `01`, opcode (`10` read, `01` write), 5-bit PHY address, 5-bit register address, 2 turnaround bits, then 16 data bits. With the preamble the frame has 64 MDC periods.
- R4: With `no_preamble` high, the preamble is left out and a frame has exactly 32 MDC periods starting with the start bits.
- R5: On a read, `mdo_en` is low from the first turnaround bit to the end of the frame. `mdi` is sampled on each rising MDC edge of the 16 data bits, MSB first, into `rd_data`. `rd_valid` clears when a read starts and sets when it ends.
- R6: On a write, `mdo_en` stays high for the whole frame, turnaround is driven `10`, and the data bits equal `wr_data`.
- R7: `busy` is high from the clock after a start until the frame ends. `done` is a one-cycle pulse in the first cycle that `busy` is low again.
- R8: Start requests that arrive while busy are ignored. Among requests seen together when idle, write wins over read, and read wins over scan.
- R9: While `scan_en` is high, read frames repeat with a short gap. The first one uses `phy_addr`. `scan_phy` shows the address of the current scan frame and holds steady during it. Clearing `scan_en` stops the scan after the frame in progress.
- R10: With `scan_inc` high, `scan_phy` goes up by one after every scan frame and wraps from 31 to 0. With `scan_inc` low it stays put.
- R11: `mdo` changes only while MDC is low, so it is stable across every interval in which MDC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_sel | input | 3 | MDC divider setting; half period = 2^div_sel clocks |
| no_preamble | input | 1 | Leave out the 32-bit preamble |
| scan_en | input | 1 | Run repeated read frames |
| scan_inc | input | 1 | Step the PHY address after each scan frame |
| rd_start | input | 1 | Pulse: start one read frame |
| wr_start | input | 1 | Pulse: start one write frame |
| phy_addr | input | 5 | PHY address (first scan address) |
| reg_addr | input | 5 | Register address within the PHY |
| wr_data | input | 16 | Control word for a write |
| mdi | input | 1 | Serial data from the PHY |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Serial data to the PHY |
| mdo_en | output | 1 | Output enable for mdo |
| rd_data | output | 16 | Result of the latest read |
| rd_valid | output | 1 | rd_data holds a finished read |
| busy | output | 1 | A frame is in progress |
| scan_phy | output | 5 | PHY address of the current scan frame |
| done | output | 1 | One-cycle pulse when a frame ends |

## Verification
The assertions assume that `div_sel`, `no_preamble`, `reg_addr`, `wr_data` and `phy_addr` do not change while `busy` is high. They also assume that start requests are one-cycle pulses. The stimulus only changes settings between frames and drives each start for a single clock. The bench's PHY model drives `mdi` only after a falling MDC edge, so the value is settled before the rising edge that samples it. `scan_en` is dropped while a scan frame is running, which keeps the stop behaviour deterministic.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = 16;
  localparam int BODY_W   = 32;
  localparam int PRE_W    = 32;
  localparam int IDX_W    = 7;
  localparam int TA_POS   = 14;
  localparam int DATA_POS = 16;

  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] TA_WRITE = 2'b10;

  typedef enum logic [1:0] {REQ_NONE, REQ_WRITE, REQ_READ, REQ_SCAN} req_e;

  // Frame body after the preamble, MSB sent first.
  function automatic logic [BODY_W-1:0] build_body(
    input logic wr, input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rg, input logic [DATA_W-1:0] d);
    return {SOF_BITS, (wr ? OP_WRITE : OP_READ), phy, rg,
            (wr ? TA_WRITE : 2'b11), (wr ? d : {DATA_W{1'b1}})};
  endfunction
endpackage

// File: rtl/phy_mgmt_clkgen.sv
module phy_mgmt_clkgen #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_sel,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  localparam int CNT_W = 1 << DIV_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic             wrap;

  assign half_m1 = (CNT_W'(1) << div_sel) - CNT_W'(1);
  assign wrap    = run && (cnt == half_m1);
  assign rise    = wrap && !mdc;
  assign fall    = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R2: the management clock rests low whenever no frame runs
  assert_mdc_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !run |=> !mdc);
endmodule

// File: rtl/phy_mgmt_engine.sv
module phy_mgmt_engine
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_rd,
  input  logic              pre_en,
  input  logic [BODY_W-1:0] body,
  input  logic              rise,
  input  logic              fall,
  input  logic              mdc,
  input  logic              mdi,
  output logic              active,
  output logic              mdo,
  output logic              mdo_en,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic              rd_mode;
  logic              pre;
  logic [IDX_W-1:0]  idx;
  logic [BODY_W-1:0] frm;
  logic [DATA_W-1:0] rd_sh;
  logic [IDX_W-1:0]  last_idx;
  logic [IDX_W-1:0]  nidx;
  logic [IDX_W-1:0]  cur_pos;
  logic [IDX_W-1:0]  nxt_pos;
  logic              cur_body;
  logic              nxt_body;

  function automatic logic bit_at(input logic p, input logic [IDX_W-1:0] i,
                                  input logic [BODY_W-1:0] f);
    logic [IDX_W-1:0] q;
    q = p ? i - IDX_W'(PRE_W) : i;
    if (p && i < IDX_W'(PRE_W)) return 1'b1;
    return f[5'd31 - q[4:0]];
  endfunction

  always_comb begin
    last_idx = pre ? IDX_W'(PRE_W + BODY_W - 1) : IDX_W'(BODY_W - 1);
    nidx     = idx + IDX_W'(1);
    cur_body = !(pre && idx < IDX_W'(PRE_W));
    nxt_body = !(pre && nidx < IDX_W'(PRE_W));
    cur_pos  = pre ? idx - IDX_W'(PRE_W) : idx;
    nxt_pos  = pre ? nidx - IDX_W'(PRE_W) : nidx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      rd_mode  <= 1'b0;
      pre      <= 1'b0;
      idx      <= '0;
      frm      <= '0;
      rd_sh    <= '0;
      mdo      <= 1'b0;
      mdo_en   <= 1'b0;
      done     <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        active  <= 1'b1;
        rd_mode <= start_rd;
        pre     <= pre_en;
        idx     <= '0;
        frm     <= body;
        mdo     <= pre_en ? 1'b1 : body[BODY_W-1];
        mdo_en  <= 1'b1;
        if (start_rd) rd_valid <= 1'b0;
      end else if (active) begin
        if (rise && rd_mode && cur_body && cur_pos >= IDX_W'(DATA_POS))
          rd_sh <= {rd_sh[DATA_W-2:0], mdi};
        if (fall) begin
          if (idx == last_idx) begin
            active <= 1'b0;
            done   <= 1'b1;
            mdo    <= 1'b0;
            mdo_en <= 1'b0;
            if (rd_mode) begin
              rd_data  <= rd_sh;
              rd_valid <= 1'b1;
            end
          end else begin
            idx    <= nidx;
            mdo    <= bit_at(pre, nidx, frm);
            mdo_en <= !(rd_mode && nxt_body && nxt_pos >= IDX_W'(TA_POS));
          end
        end
      end
    end
  end

  // R11: data toggles only while the management clock is low
  assert_mdo_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> $stable(mdo));
  // R7: the done pulse never overlaps a running frame
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !active);
  // R5: a running read never shows stale data as valid
  assert_valid_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (active && rd_mode) |-> !rd_valid);
  // R5: the line is released while the PHY returns data
  assert_release_R5: assert property (@(posedge clk) disable iff (rst)
    (active && rd_mode && cur_body && cur_pos >= IDX_W'(DATA_POS)) |-> !mdo_en);
endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int DIV_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic              no_preamble,
  input  logic              scan_en,
  input  logic              scan_inc,
  input  logic              rd_start,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mdi,
  output logic              mdc,
  output logic              mdo,
  output logic              mdo_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic [ADDR_W-1:0] scan_phy,
  output logic              done
);
  req_e              req;
  logic              go;
  logic              active;
  logic              eng_done;
  logic              rise;
  logic              fall;
  logic              scan_run;
  logic              cur_scan;
  logic [ADDR_W-1:0] scan_ph;
  logic [ADDR_W-1:0] addr_sel;
  logic [BODY_W-1:0] body;

  always_comb begin
    req = REQ_NONE;
    if (!active && !eng_done) begin
      if (wr_start)     req = REQ_WRITE;
      else if (rd_start) req = REQ_READ;
      else if (scan_en)  req = REQ_SCAN;
    end
    go       = (req != REQ_NONE);
    addr_sel = (req == REQ_SCAN && scan_run) ? scan_ph : phy_addr;
    body     = build_body(req == REQ_WRITE, addr_sel, reg_addr, wr_data);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_run <= 1'b0;
      scan_ph  <= '0;
      cur_scan <= 1'b0;
    end else begin
      if (go) begin
        cur_scan <= (req == REQ_SCAN);
        if (req == REQ_SCAN) begin
          scan_run <= 1'b1;
          scan_ph  <= addr_sel;
        end
      end else if (eng_done && cur_scan && scan_inc) begin
        scan_ph <= scan_ph + ADDR_W'(1);
      end
      if (!scan_en && !active && !eng_done) scan_run <= 1'b0;
    end
  end

  phy_mgmt_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(active), .div_sel(div_sel),
    .mdc(mdc), .rise(rise), .fall(fall)
  );

  phy_mgmt_engine u_eng (
    .clk(clk), .rst(rst), .start(go), .start_rd(req != REQ_WRITE),
    .pre_en(!no_preamble), .body(body), .rise(rise), .fall(fall),
    .mdc(mdc), .mdi(mdi), .active(active), .mdo(mdo), .mdo_en(mdo_en),
    .done(eng_done), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assign busy     = active;
  assign done     = eng_done;
  assign scan_phy = scan_ph;

  // R7: every end of busy comes with the done pulse
  assert_busy_fall_done_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R9: the reported scan address holds during a frame
  assert_scan_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(scan_phy));
  // R10: a finished scan frame with increment steps the address by one
  assert_scan_step_R10: assert property (@(posedge clk) disable iff (rst)
    (done && cur_scan && scan_inc) |=> (scan_phy == $past(scan_phy) + 5'd1));
endmodule

// File: tb/phy_mgmt_ctrl_test.sv
`timescale 1ns/1ps
module phy_mgmt_ctrl_test;
  typedef struct {
    bit        wr;
    bit [4:0]  phy;
    bit [4:0]  rg;
    bit [15:0] data;
    bit        pre;
    bit        scan;
    int        half;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] div_sel = 3'd0;
  logic no_preamble = 1'b0, scan_en = 1'b0, scan_inc = 1'b0;
  logic rd_start = 1'b0, wr_start = 1'b0;
  logic [4:0] phy_addr = '0, reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic mdi = 1'b1;
  logic mdc, mdo, mdo_en, rd_valid, busy, done;
  logic [15:0] rd_data;
  logic [4:0] scan_phy;

  int errors = 0, checks = 0, dones = 0, viol = 0;
  item_t q[$];

  bit mdo_bits[64];
  bit en_bits[64];
  int rises = 0;
  realtime last_rise = 0, period = 0;
  bit prev_mdc = 0, prev_mdo = 0;

  always #5 clk = ~clk;

  phy_mgmt_ctrl uut (
    .clk(clk), .rst(rst), .div_sel(div_sel), .no_preamble(no_preamble),
    .scan_en(scan_en), .scan_inc(scan_inc), .rd_start(rd_start),
    .wr_start(wr_start), .phy_addr(phy_addr), .reg_addr(reg_addr),
    .wr_data(wr_data), .mdi(mdi), .mdc(mdc), .mdo(mdo), .mdo_en(mdo_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
    .scan_phy(scan_phy), .done(done)
  );

  function automatic bit [15:0] phy_val(bit [4:0] p, bit [4:0] r);
    return {p, 6'b101100, r};
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // PHY model: captures the frame on rising MDC, answers reads after falling MDC
  always @(posedge busy) rises = 0;
  always @(posedge mdc) begin
    if (rises < 64) begin
      mdo_bits[rises] = mdo;
      en_bits[rises]  = mdo_en;
    end
    if (rises > 0) period = $realtime - last_rise;
    last_rise = $realtime;
    rises++;
  end
  always @(negedge mdc) begin
    int off, p;
    bit [4:0] ph, rg;
    #1;
    off = mdo_bits[0] ? 32 : 0;
    p = rises - 1 - off;
    if (p >= 15 && p <= 30 && mdo_bits[off+2] && !mdo_bits[off+3]) begin
      for (int k = 0; k < 5; k++) begin
        ph[4-k] = mdo_bits[off+4+k];
        rg[4-k] = mdo_bits[off+9+k];
      end
      mdi = phy_val(ph, rg)[30-p];
    end else begin
      mdi = 1'b1;
    end
  end

  // R11 watcher: mdo must not move while MDC stays high
  always @(negedge clk) begin
    if (mdc && prev_mdc && mdo != prev_mdo) viol++;
    prev_mdc = mdc;
    prev_mdo = mdo;
  end

  // Monitor: pops the scoreboard on every done pulse
  always @(negedge clk) begin
    if (!rst && done) begin
      item_t it;
      int off;
      bit [13:0] hdr;
      bit [17:0] tail;
      dones++;
      if (q.size() == 0) begin
        chk(0, "R8", "unexpected frame", 1, 0);
      end else begin
        it = q.pop_front();
        off = it.pre ? 32 : 0;
        hdr = {2'b01, (it.wr ? 2'b01 : 2'b10), it.phy, it.rg};
        chk(rises == off + 32, it.pre ? "R3" : "R4", "MDC periods", rises, off + 32);
        for (int k = 0; k < off; k++)
          if (!mdo_bits[k]) chk(0, "R3", "preamble bit", k, 1);
        for (int k = 0; k < 14; k++)
          if (mdo_bits[off+k] != hdr[13-k]) chk(0, "R3", "header bit", k, hdr[13-k]);
        chk(1, "R3", "header", 0, 0);
        chk(period == 2.0 * it.half * 10.0, "R2", "MDC period ns", int'(period), 2 * it.half * 10);
        if (it.wr) begin
          tail = {2'b10, it.data};
          for (int k = 0; k < 18; k++) begin
            if (mdo_bits[off+14+k] != tail[17-k]) chk(0, "R6", "write bit", k, tail[17-k]);
            if (!en_bits[off+14+k]) chk(0, "R6", "write enable", k, 1);
          end
          chk(1, "R6", "write body", 0, 0);
        end else begin
          for (int k = 14; k < 32; k++)
            if (en_bits[off+k]) chk(0, "R5", "released during", k, 0);
          chk(rd_data == phy_val(it.phy, it.rg), "R5", "rd_data", rd_data, phy_val(it.phy, it.rg));
          chk(rd_valid == 1'b1, "R5", "rd_valid", rd_valid, 1);
        end
        if (it.scan) chk(scan_phy == it.phy, "R9", "scan_phy", scan_phy, it.phy);
      end
    end
  end

  task automatic push(bit wr, bit [4:0] ph, bit [4:0] rg, bit [15:0] d, bit pre, bit sc, int dsel);
    item_t it;
    it.wr = wr; it.phy = ph; it.rg = rg; it.data = d;
    it.pre = pre; it.scan = sc; it.half = 1 << dsel;
    q.push_back(it);
  endtask

  task automatic finish_frame();
    @(negedge clk);
    wait (!busy);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic single(bit wr, bit [4:0] ph, bit [4:0] rg, bit [15:0] d, bit pre, int dsel);
    @(negedge clk);
    phy_addr = ph; reg_addr = rg; wr_data = d;
    no_preamble = !pre; div_sel = 3'(dsel);
    push(wr, ph, rg, d, pre, 0, dsel);
    if (wr) wr_start = 1'b1; else rd_start = 1'b1;
    @(negedge clk);
    wr_start = 1'b0; rd_start = 1'b0;
    chk(busy == 1'b1, "R7", "busy after start", busy, 1);
    if (!wr) chk(rd_valid == 1'b0, "R5", "valid cleared", rd_valid, 0);
    finish_frame();
  endtask

  initial begin
    #1500000;
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && mdc == 0 && mdo_en == 0, "R1", "busy/mdc/mdo_en", {busy, mdc, mdo_en}, 0);
    chk(rd_valid == 0 && done == 0 && scan_phy == 0, "R1", "valid/done/scan_phy", {rd_valid, done, scan_phy}, 0);

    // R3 R5 R2: read with preamble
    single(0, 5'd5, 5'd3, 16'h0, 1, 1);
    // R4 R6: write without preamble, fastest clock
    single(1, 5'd17, 5'd22, 16'hA5C3, 0, 0);
    // R2: slower divider, read without preamble
    single(0, 5'd9, 5'd1, 16'h0, 0, 2);
    chk(mdc == 1'b0, "R2", "mdc idle low", mdc, 0);

    // R8: requests while busy are ignored
    base = dones;
    @(negedge clk);
    phy_addr = 5'd2; reg_addr = 5'd4; no_preamble = 0; div_sel = 3'd0;
    push(0, 5'd2, 5'd4, 16'h0, 1, 0, 0);
    rd_start = 1'b1;
    @(negedge clk); rd_start = 1'b0;
    repeat (3) @(negedge clk);
    wr_start = 1'b1; rd_start = 1'b1;
    @(negedge clk); wr_start = 1'b0; rd_start = 1'b0;
    finish_frame();
    repeat (40) @(negedge clk);
    chk(dones == base + 1 && busy == 0, "R8", "ignored while busy", dones - base, 1);

    // R8: write wins over read when both arrive idle
    @(negedge clk);
    phy_addr = 5'd12; reg_addr = 5'd0; wr_data = 16'h1234;
    push(1, 5'd12, 5'd0, 16'h1234, 1, 0, 0);
    wr_start = 1'b1; rd_start = 1'b1;
    @(negedge clk); wr_start = 1'b0; rd_start = 1'b0;
    finish_frame();
    chk(q.size() == 0, "R8", "priority frame consumed", q.size(), 0);

    // R9 R10: scan with increment wraps 30, 31, 0
    base = dones;
    @(negedge clk);
    phy_addr = 5'd30; reg_addr = 5'd7; scan_inc = 1'b1; no_preamble = 0; div_sel = 3'd0;
    push(0, 5'd30, 5'd7, 0, 1, 1, 0);
    push(0, 5'd31, 5'd7, 0, 1, 1, 0);
    push(0, 5'd0, 5'd7, 0, 1, 1, 0);
    scan_en = 1'b1;
    wait (dones == base + 2);
    @(posedge busy);
    @(negedge clk);
    scan_en = 1'b0;
    finish_frame();
    repeat (300) @(negedge clk);
    chk(dones == base + 3 && busy == 0, "R9", "scan stops", dones - base, 3);
    chk(scan_phy == 5'd1, "R10", "scan_phy after wrap", scan_phy, 1);

    // R10: scan without increment stays on one PHY
    base = dones;
    @(negedge clk);
    phy_addr = 5'd9; reg_addr = 5'd2; scan_inc = 1'b0;
    push(0, 5'd9, 5'd2, 0, 1, 1, 0);
    push(0, 5'd9, 5'd2, 0, 1, 1, 0);
    scan_en = 1'b1;
    wait (dones == base + 1);
    @(posedge busy);
    @(negedge clk);
    scan_en = 1'b0;
    finish_frame();
    repeat (300) @(negedge clk);
    chk(dones == base + 2, "R10", "no-increment frames", dones - base, 2);
    chk(scan_phy == 5'd9, "R10", "scan_phy held", scan_phy, 9);

    chk(viol == 0, "R11", "mdo moves while MDC high", viol, 0);
    chk(q.size() == 0, "R7", "all frames completed", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule